// File: doc/BRIEF.md
# Nested Interrupt Status Gate

This block decides whether an interrupt request may be taken, based on how deeply the processor is already nested in interrupt service. A 2-bit nesting level acts as the state of a small machine. At the lowest level every pending source may be taken. One level up, only sources marked high priority may be taken. At the top level nothing is taken. The fourth code has no defined meaning, so it is treated as fully closed and flagged as illegal.

Each time a request is taken, the current level is saved on a three-entry last-in-first-out stack and the level steps up by one. A return event from the service routine pops the saved level back. Software may load the level directly, but only while interrupts are globally disabled. Among the sources that pass the gate, high-priority sources come before normal ones, and within a class the lowest-numbered source wins.

The level states are LVL_ALL (00), LVL_HIONLY (01), LVL_NONE (10) and LVL_UNDEF (11). The transitions are:
- EV_STEP: taking a request moves ALL to HIONLY and HIONLY to NONE.
- EV_RESTORE: a return loads the popped value.
- EV_SWLOAD: a software write loads the written value.
- EV_HOLD: in every other cycle the level is kept.

Top module: `nest_irq_gate`

## Requirements
- R1: After synchronous active-high reset, status_o is 00, the save stack is empty, gie_o is 0, and accept_o, accept_idx_o, illegal_o, wr_err_o, ovf_o and unf_o are all 0.
- R2: A request is taken only in a cycle where gie_o is 1 and core_rdy_i is 1. At level 00, any pending source, high or normal, may be taken.
- R3: At level 01, only sources whose hi_mask_i bit is 1 may be taken. Pending normal sources are left waiting.
- R4: At level 10 nothing is taken. Level 11 blocks the same way, and illegal_o is 1 for as long as status_o is 11.
- R5: Among eligible sources, the sources with hi_mask_i bit 1 are considered first, and within the chosen class the lowest index wins.
- R6: When a request is taken at clock edge k, accept_o is 1 for exactly the cycle after edge k. In that cycle accept_idx_o holds the source index, and status_o has stepped from 00 to 01 or from 01 to 10. The old level is pushed on the stack. In every other cycle accept_idx_o reads 0.
- R7: When ret_i is high at an edge and the stack is not empty, status_o takes the most recently saved level after that edge.
- R8: No request is taken at an edge where ret_i is high.
- R9: A pulse on sw_wr_i loads sw_val_i into status_o after the edge, but only when gie_o is 0 and ret_i is low. Otherwise the write is ignored and wr_err_o is 1 for one cycle.
- R10: If a request would be taken while the stack already holds 3 entries, the request is not taken, ovf_o is 1 for one cycle, and status_o is unchanged.
- R11: A return with an empty stack sets unf_o for one cycle and leaves status_o unchanged.
- R12: A pulse on en_wr_i loads en_val_i into the global enable, and gie_o shows the new value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Pending request per source |
| hi_mask_i | input | NUM_SRC | 1 marks a source as high priority |
| core_rdy_i | input | 1 | Core can take an interrupt this cycle |
| ret_i | input | 1 | Return from service routine |
| sw_wr_i | input | 1 | Software write strobe for the level |
| sw_val_i | input | 2 | Level value to write |
| en_wr_i | input | 1 | Write strobe for the global enable |
| en_val_i | input | 1 | Global enable value to write |
| accept_o | output | 1 | One-cycle strobe: a request was taken |
| accept_idx_o | output | IDX_W | Index of the taken source |
| status_o | output | 2 | Current nesting level |
| illegal_o | output | 1 | Level holds the undefined code 11 |
| gie_o | output | 1 | Global enable |
| wr_err_o | output | 1 | A software level write was refused |
| ovf_o | output | 1 | Take refused because the stack is full |
| unf_o | output | 1 | Return with an empty stack |

## Verification
A wrong level shows on status_o in the cycle after the edge that caused it. It then shows a second time on the next request: an accept appears, or fails to appear, in the cycle after the deciding edge. A corrupt stack entry stays hidden until a later return pops it. For that reason the bench fills the stack to its limit and then unwinds it, checking the restored level after each return. Priority and index errors show directly on accept_idx_o in the cycle after each take.

// File: rtl/nig_pkg.sv
package nig_pkg;

    typedef enum logic [1:0] {
        LVL_ALL    = 2'b00,
        LVL_HIONLY = 2'b01,
        LVL_NONE   = 2'b10,
        LVL_UNDEF  = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        EV_HOLD,
        EV_STEP,
        EV_RESTORE,
        EV_SWLOAD
    } lvl_ev_e;

endpackage

// File: rtl/nig_prio_pick.sv
module nig_prio_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    logic [N-1:0] first;

    for (genvar g = 0; g < N; g++) begin : g_first
        if (g == 0) begin : g_lsb
            assign first[g] = req_i[g];
        end else begin : g_upper
            assign first[g] = req_i[g] & ~(|req_i[g-1:0]);
        end
    end

    assign found_o = |req_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx_o = IW'(i);
        end
    end

    // R5: the chosen bit is set and no lower bit is set
    always_comb begin
        if (found_o) begin
            assert_pick_lowest_R5: assert (req_i[idx_o] && (first == (N'(1) << idx_o)));
        end
    end

endmodule

// File: rtl/nig_save_stack.sv
module nig_save_stack #(
    parameter int DEPTH = 3,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o,
    output logic         full_o,
    output logic         empty_o
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot [DEPTH];
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push_i) begin
            cnt <= cnt + CW'(1);
        end else if (pop_i) begin
            cnt <= cnt - CW'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_i && cnt == CW'(g)) slot[g] <= din_i;
        end
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CW'(i + 1)) top_o = slot[i];
        end
    end

    assign full_o  = (cnt == CW'(DEPTH));
    assign empty_o = (cnt == '0);

    assert_no_push_full_R10: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o);
    assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o);
    assert_push_pop_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(push_i && pop_i));
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/nig_level_ctl.sv
module nig_level_ctl
    import nig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lvl_ev_e    ev_i,
    input  logic [1:0] pop_val_i,
    input  logic [1:0] sw_val_i,
    output lvl_e       lvl_o
);

    lvl_e lvl_q, lvl_nx;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= LVL_ALL;
        else     lvl_q <= lvl_nx;
    end

    always_comb begin
        lvl_nx = lvl_q;
        unique case (ev_i)
            EV_HOLD:    lvl_nx = lvl_q;
            EV_STEP: begin
                unique case (lvl_q)
                    LVL_ALL:    lvl_nx = LVL_HIONLY;
                    LVL_HIONLY: lvl_nx = LVL_NONE;
                    LVL_NONE:   lvl_nx = lvl_q;
                    LVL_UNDEF:  lvl_nx = lvl_q;
                endcase
            end
            EV_RESTORE: lvl_nx = lvl_e'(pop_val_i);
            EV_SWLOAD:  lvl_nx = lvl_e'(sw_val_i);
        endcase
    end

    assign lvl_o = lvl_q;

    assert_step_from_open_R6: assert property (@(posedge clk) disable iff (rst)
        (ev_i == EV_STEP) |-> (lvl_q == LVL_ALL || lvl_q == LVL_HIONLY));
    assert_step_legal_R6: assert property (@(posedge clk) disable iff (rst)
        (ev_i == EV_STEP && lvl_q == LVL_ALL) |=> (lvl_q == LVL_HIONLY));

endmodule

// File: rtl/nest_irq_gate.sv
module nest_irq_gate
    import nig_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int STACK_DEPTH = 3,
    parameter int IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] hi_mask_i,
    input  logic               core_rdy_i,
    input  logic               ret_i,
    input  logic               sw_wr_i,
    input  logic [1:0]         sw_val_i,
    input  logic               en_wr_i,
    input  logic               en_val_i,
    output logic               accept_o,
    output logic [IDX_W-1:0]   accept_idx_o,
    output logic [1:0]         status_o,
    output logic               illegal_o,
    output logic               gie_o,
    output logic               wr_err_o,
    output logic               ovf_o,
    output logic               unf_o
);

    localparam logic [NUM_SRC-1:0] ONE_N = NUM_SRC'(1);

    lvl_e               lvl;
    lvl_ev_e            ev;
    logic               gie_q;
    logic [1:0]         top_val;
    logic               stk_full, stk_empty;
    logic [NUM_SRC-1:0] cls_req [2];
    logic [1:0]         cls_found;
    logic [IDX_W-1:0]   cls_idx [2];

    logic allow_hi, allow_lo, use_hi, cand, take, ovf_ev, pop, unf_ev, sw_ok, werr_ev;
    logic [IDX_W-1:0] sel_idx;

    // class 0 = high priority, class 1 = normal
    assign cls_req[0] = req_i & hi_mask_i;
    assign cls_req[1] = req_i & ~hi_mask_i;

    for (genvar c = 0; c < 2; c++) begin : g_cls
        nig_prio_pick #(.N(NUM_SRC), .IW(IDX_W)) pick_i (
            .req_i   (cls_req[c]),
            .found_o (cls_found[c]),
            .idx_o   (cls_idx[c])
        );
    end

    // gate by nesting level
    always_comb begin
        allow_hi = 1'b0;
        allow_lo = 1'b0;
        unique case (lvl)
            LVL_ALL:    begin allow_hi = 1'b1; allow_lo = 1'b1; end
            LVL_HIONLY: allow_hi = 1'b1;
            LVL_NONE:   ;
            LVL_UNDEF:  ;
        endcase
    end

    assign use_hi  = allow_hi && cls_found[0];
    assign cand    = gie_q && core_rdy_i && !ret_i && (use_hi || (allow_lo && cls_found[1]));
    assign sel_idx = use_hi ? cls_idx[0] : cls_idx[1];
    assign take    = cand && !stk_full;
    assign ovf_ev  = cand && stk_full;
    assign pop     = ret_i && !stk_empty;
    assign unf_ev  = ret_i && stk_empty;
    assign sw_ok   = sw_wr_i && !gie_q && !ret_i;
    assign werr_ev = sw_wr_i && !sw_ok;

    always_comb begin
        if (pop)        ev = EV_RESTORE;
        else if (take)  ev = EV_STEP;
        else if (sw_ok) ev = EV_SWLOAD;
        else            ev = EV_HOLD;
    end

    nig_level_ctl level_i (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev),
        .pop_val_i (top_val),
        .sw_val_i  (sw_val_i),
        .lvl_o     (lvl)
    );

    nig_save_stack #(.DEPTH(STACK_DEPTH), .W(2)) stack_i (
        .clk     (clk),
        .rst     (rst),
        .push_i  (take),
        .pop_i   (pop),
        .din_i   (lvl),
        .top_o   (top_val),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    // global enable register
    always_ff @(posedge clk) begin
        if (rst)          gie_q <= 1'b0;
        else if (en_wr_i) gie_q <= en_val_i;
    end

    // registered strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            accept_o     <= 1'b0;
            accept_idx_o <= '0;
            wr_err_o     <= 1'b0;
            ovf_o        <= 1'b0;
            unf_o        <= 1'b0;
        end else begin
            accept_o     <= take;
            accept_idx_o <= take ? sel_idx : '0;
            wr_err_o     <= werr_ev;
            ovf_o        <= ovf_ev;
            unf_o        <= unf_ev;
        end
    end

    assign status_o  = lvl;
    assign illegal_o = (lvl == LVL_UNDEF);
    assign gie_o     = gie_q;

    assert_gate_closed_R4: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_NONE || lvl == LVL_UNDEF) |=> !accept_o);
    assert_ret_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        ret_i |=> !accept_o);
    assert_accept_raises_R6: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> (status_o == 2'($past(status_o) + 2'd1)));
    assert_hionly_src_R3: assert property (@(posedge clk) disable iff (rst)
        (accept_o && $past(lvl) == LVL_HIONLY) |->
        ((($past(hi_mask_i) >> accept_idx_o) & ONE_N) != '0));
    assert_wr_refused_R9: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_i && gie_q) |=> wr_err_o);
    assert_ovf_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ovf_ev |=> (ovf_o && !accept_o && status_o == $past(status_o)));
    assert_unf_hold_R11: assert property (@(posedge clk) disable iff (rst)
        unf_ev |=> (unf_o && status_o == $past(status_o)));
    assert_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        (!gie_q || !core_rdy_i) |=> !accept_o);

endmodule

// File: tb/nest_irq_gate_tb_top.sv
module nest_irq_gate_tb_top;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  hi = '0;
    logic          rdy = 1'b0;
    logic          ret = 1'b0;
    logic          sw = 1'b0;
    logic [1:0]    swd = 2'b00;
    logic          enw = 1'b0;
    logic          env = 1'b0;

    logic          accept;
    logic [IW-1:0] idx;
    logic [1:0]    status;
    logic          illegal, gie, werr, ovf, unf;

    always #10 clk = ~clk;

    nest_irq_gate #(.NUM_SRC(N), .STACK_DEPTH(3)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .hi_mask_i    (hi),
        .core_rdy_i   (rdy),
        .ret_i        (ret),
        .sw_wr_i      (sw),
        .sw_val_i     (swd),
        .en_wr_i      (enw),
        .en_val_i     (env),
        .accept_o     (accept),
        .accept_idx_o (idx),
        .status_o     (status),
        .illegal_o    (illegal),
        .gie_o        (gie),
        .wr_err_o     (werr),
        .ovf_o        (ovf),
        .unf_o        (unf)
    );

    typedef struct {
        logic [10:0] v;   // {acc, idx[2:0], st[1:0], ill, gie, werr, ovf, unf}
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   cycles = 0;
    bit   done   = 0;

    // monitor: compares the item pushed before the previous rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            logic [10:0] got;
            e   = q.pop_front();
            got = {accept, idx, status, illegal, gie, werr, ovf, unf};
            n_chk++;
            if (got !== e.v) begin
                n_fail++;
                $display("FAIL %s: got acc=%0b idx=%0d st=%0b ill=%0b gie=%0b werr=%0b ovf=%0b unf=%0b expected acc=%0b idx=%0d st=%0b ill=%0b gie=%0b werr=%0b ovf=%0b unf=%0b",
                         e.tag, got[10], got[9:7], got[6:5], got[4], got[3], got[2], got[1], got[0],
                         e.v[10], e.v[9:7], e.v[6:5], e.v[4], e.v[3], e.v[2], e.v[1], e.v[0]);
            end
        end
    end

    // driver: apply inputs at the falling edge, queue what must appear after the next rising edge
    task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] h, input logic rd,
                       input logic rt, input logic w, input logic [1:0] wd,
                       input logic ew, input logic ev,
                       input logic e_acc, input logic [2:0] e_idx, input logic [1:0] e_st,
                       input logic e_ill, input logic e_gie, input logic e_werr,
                       input logic e_ovf, input logic e_unf, input string tag);
        exp_t e;
        req = r; hi = h; rdy = rd; ret = rt; sw = w; swd = wd; enw = ew; env = ev;
        e.v   = {e_acc, e_idx, e_st, e_ill, e_gie, e_werr, e_ovf, e_unf};
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 0, 0,  0, 0, 2'd0, 0, 0, 0, 0, 0, "R1 reset state");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, 1,  0, 0, 2'd0, 0, 1, 0, 0, 0, "R12 enable on");
        cyc(8'h24, 8'h00, 0, 0, 0, 2'd0, 0, 0,  0, 0, 2'd0, 0, 1, 0, 0, 0, "R2 core not ready");
        cyc(8'h24, 8'h00, 1, 0, 0, 2'd0, 0, 0,  1, 2, 2'd1, 0, 1, 0, 0, 0, "R2 R6 take at level 00");
        cyc(8'h00, 8'h00, 1, 0, 0, 2'd0, 0, 0,  0, 0, 2'd1, 0, 1, 0, 0, 0, "R6 strobe one cycle");
        cyc(8'h04, 8'h00, 1, 0, 0, 2'd0, 0, 0,  0, 0, 2'd1, 0, 1, 0, 0, 0, "R3 normal blocked at 01");
        cyc(8'h44, 8'h40, 1, 0, 0, 2'd0, 0, 0,  1, 6, 2'd2, 0, 1, 0, 0, 0, "R3 R5 high taken at 01");
        cyc(8'hFF, 8'hFF, 1, 0, 0, 2'd0, 0, 0,  0, 0, 2'd2, 0, 1, 0, 0, 0, "R4 level 10 blocks");
        cyc(8'h00, 8'h00, 0, 1, 0, 2'd0, 0, 0,  0, 0, 2'd1, 0, 1, 0, 0, 0, "R7 return restores 01");
        cyc(8'h40, 8'h40, 1, 1, 0, 2'd0, 0, 0,  0, 0, 2'd0, 0, 1, 0, 0, 0, "R8 R7 no take on return");
        cyc(8'h00, 8'h00, 0, 1, 0, 2'd0, 0, 0,  0, 0, 2'd0, 0, 1, 0, 0, 1, "R11 underflow");
        cyc(8'h00, 8'h00, 0, 0, 1, 2'd2, 0, 0,  0, 0, 2'd0, 0, 1, 1, 0, 0, "R9 write refused when enabled");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, 0,  0, 0, 2'd0, 0, 0, 0, 0, 0, "R12 enable off");
        cyc(8'h00, 8'h00, 0, 0, 1, 2'd3, 0, 0,  0, 0, 2'd3, 1, 0, 0, 0, 0, "R9 R4 write 11 illegal");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, 1,  0, 0, 2'd3, 1, 1, 0, 0, 0, "R12 enable on");
        cyc(8'hFF, 8'hFF, 1, 0, 0, 2'd0, 0, 0,  0, 0, 2'd3, 1, 1, 0, 0, 0, "R4 level 11 blocks");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, 0,  0, 0, 2'd3, 1, 0, 0, 0, 0, "R12 enable off");
        cyc(8'h00, 8'h00, 0, 0, 1, 2'd0, 0, 0,  0, 0, 2'd0, 0, 0, 0, 0, 0, "R9 write 00");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, 1,  0, 0, 2'd0, 0, 1, 0, 0, 0, "R12 enable on");
        cyc(8'h30, 8'h20, 1, 0, 0, 2'd0, 0, 0,  1, 5, 2'd1, 0, 1, 0, 0, 0, "R5 high before normal");
        cyc(8'h0A, 8'h0A, 1, 0, 0, 2'd0, 0, 0,  1, 1, 2'd2, 0, 1, 0, 0, 0, "R5 lowest high index");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, 0,  0, 0, 2'd2, 0, 0, 0, 0, 0, "R12 enable off");
        cyc(8'h00, 8'h00, 0, 0, 1, 2'd0, 0, 0,  0, 0, 2'd0, 0, 0, 0, 0, 0, "R9 write 00");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, 1,  0, 0, 2'd0, 0, 1, 0, 0, 0, "R12 enable on");
        cyc(8'h80, 8'h00, 1, 0, 0, 2'd0, 0, 0,  1, 7, 2'd1, 0, 1, 0, 0, 0, "R6 third push");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, 0,  0, 0, 2'd1, 0, 0, 0, 0, 0, "R12 enable off");
        cyc(8'h00, 8'h00, 0, 0, 1, 2'd0, 0, 0,  0, 0, 2'd0, 0, 0, 0, 0, 0, "R9 write 00");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, 1,  0, 0, 2'd0, 0, 1, 0, 0, 0, "R12 enable on");
        cyc(8'h01, 8'h00, 1, 0, 0, 2'd0, 0, 0,  0, 0, 2'd0, 0, 1, 0, 1, 0, "R10 overflow");
        cyc(8'h00, 8'h00, 0, 1, 0, 2'd0, 0, 0,  0, 0, 2'd0, 0, 1, 0, 0, 0, "R7 pop third entry");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 1, 0,  0, 0, 2'd0, 0, 0, 0, 0, 0, "R12 enable off");
        cyc(8'h01, 8'h00, 1, 0, 0, 2'd0, 0, 0,  0, 0, 2'd0, 0, 0, 0, 0, 0, "R2 disabled blocks");
        cyc(8'h00, 8'h00, 0, 1, 1, 2'd1, 0, 0,  0, 0, 2'd1, 0, 0, 1, 0, 0, "R9 R7 write lost to return");
        cyc(8'h00, 8'h00, 0, 1, 0, 2'd0, 0, 0,  0, 0, 2'd0, 0, 0, 0, 0, 0, "R7 pop first entry");
        cyc(8'h00, 8'h00, 0, 0, 0, 2'd0, 0, 0,  0, 0, 2'd0, 0, 0, 0, 0, 0, "R6 R1 idle all clear");
        repeat (3) @(negedge clk);
        done = 1;
    end

    initial begin
        while (!done && cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule